// File: doc/BRIEF.md
# Serial Interface Mode Control Register

This block is the 8-bit control register of a two-wire serial interface that can run as a bus master or as a slave. Software writes it through a simple register port. The register holds these fields:

- an interface enable;
- a bit that holds off further reception;
- the master select and the transmit select;
- a 4-bit transfer-clock select.

The block decodes these fields into the current operating mode, a pin-drive enable, a clock-output enable and a clock-select value. These outputs go to a separate byte-transfer engine and to a clock divider.

Hardware also writes the register.

- **Arbitration loss:** when the bus protocol format is in use and arbitration is lost while the block is master, both select bits are cleared. The interface then drops back to slave receive.
- **Receive-data reads:** each read of the receive data register is gated. A one-cycle permit pulse tells the engine whether the next byte may be received.
- **Transmit-select writes during a frame:** such a write is held back. It is applied once the engine reports that the frame has ended.

Top module: `serial_mode_ctl`

## Requirements
- R1: After reset, every register bit reads 0, the mode is 00, and `rx_permit`, `pins_drive`, `clk_out_en` and `clk_sel` are 0.
- R2: A write stores all eight bits. They read back on `reg_rdata` from the edge after the write. The bit layout is: bit 7 enable, bit 6 reception hold, bit 5 master select, bit 4 transmit select, bits 3..0 clock select.
- R3: `pins_drive` equals the enable bit. When it is 0 the pins return to general port use.
- R4: `mode` is {master select, transmit select}. The codes are 00 slave receive, 01 slave transmit, 10 master receive and 11 master transmit.
- R5: In bus protocol format (`fmt_sync`=0), `arb_lost` while master select is 1 clears both master select and transmit select at the next edge. In clocked synchronous format (`fmt_sync`=1), `arb_lost` has no effect.
- R6: When an arbitration-loss clear and a register write fall in the same cycle, master select and transmit select end up 0. The written enable, hold and clock-select bits still take effect.
- R7: `rx_permit` pulses for one cycle, at the edge after a `rx_rd` strobe, only if enable=1, transmit select=0 and reception hold=0. Otherwise it stays 0.
- R8: `clk_sel` carries the clock-select field when master select is 1, and is 0 in slave mode.
- R9: `clk_out_en` is 1 exactly when enable, master select and `fmt_sync` are all 1.
- R10: A write made while `frame_busy`=1 and `frame_done`=0 leaves transmit select unchanged, while its other bits apply at once. The held transmit-select value is applied at the edge where `frame_done`=1.
- R11: An arbitration-loss clear discards any held transmit-select write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| rx_rd | input | 1 | Receive data register read strobe |
| fmt_sync | input | 1 | 1: clocked synchronous format, 0: bus protocol format |
| arb_lost | input | 1 | Arbitration lost indication from the engine |
| frame_busy | input | 1 | A transfer frame is in progress |
| frame_done | input | 1 | The current frame ends this cycle |
| mode | output | 2 | Operating mode {master, transmit} |
| pins_drive | output | 1 | Clock and data pins in bus-drive state |
| clk_out_en | output | 1 | Drive the transfer clock out |
| clk_sel | output | 4 | Effective transfer clock select |
| rx_permit | output | 1 | One-cycle permit for the next reception |

## Verification
Every register update (write, arbitration clear and deferred transmit-select apply) lands at the first clock edge after the cycle in which its stimulus is held. The decoded outputs are combinational from the register, so they are due at that same edge. `rx_permit` is registered and is due one edge after the `rx_rd` strobe; it must be gone one edge later. The bench drives inputs just after a rising edge, advances exactly one edge per stimulus, and samples one time unit after that edge. For the held write, it also samples in the cycles before `frame_done` to confirm the old value persists.

// File: rtl/smc_pkg.sv
package smc_pkg;
    localparam int REG_W  = 8;
    localparam int CKS_W  = 4;
    localparam int MODE_W = 2;
    localparam int B_EN   = 7;
    localparam int B_HOLD = 6;
    localparam int B_MST  = 5;
    localparam int B_TRS  = 4;

    typedef struct packed {
        logic             en;
        logic             rx_hold;
        logic             mst;
        logic             trs;
        logic [CKS_W-1:0] cks;
    } ctl_t;

    typedef struct packed {
        ctl_t ctl;
        logic pend_v;
        logic pend_trs;
        logic rx_permit;
    } state_t;
endpackage

// File: rtl/smc_regs.sv
module smc_regs
    import smc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             rx_rd,
    input  logic             fmt_sync,
    input  logic             arb_lost,
    input  logic             frame_busy,
    input  logic             frame_done,
    output ctl_t             ctl,
    output logic             rx_permit
);
    state_t s_d, s_q;
    logic   trs_defer;
    logic   arb_clear;

    always_comb begin
        s_d       = s_q;
        trs_defer = frame_busy & ~frame_done;
        arb_clear = arb_lost & s_q.ctl.mst & ~fmt_sync;

        // reception gating: decided on current register contents
        s_d.rx_permit = rx_rd & s_q.ctl.en & ~s_q.ctl.trs & ~s_q.ctl.rx_hold;

        // apply a held transmit-select write once the frame ends
        if (frame_done && s_q.pend_v) begin
            s_d.ctl.trs = s_q.pend_trs;
            s_d.pend_v  = 1'b0;
        end

        if (reg_wr) begin
            s_d.ctl.en      = reg_wdata[B_EN];
            s_d.ctl.rx_hold = reg_wdata[B_HOLD];
            s_d.ctl.mst     = reg_wdata[B_MST];
            s_d.ctl.cks     = reg_wdata[CKS_W-1:0];
            if (trs_defer) begin
                s_d.pend_v   = 1'b1;
                s_d.pend_trs = reg_wdata[B_TRS];
            end else begin
                s_d.ctl.trs  = reg_wdata[B_TRS];
                s_d.pend_v   = 1'b0;
            end
        end

        // arbitration fallback has the last word
        if (arb_clear) begin
            s_d.ctl.mst = 1'b0;
            s_d.ctl.trs = 1'b0;
            s_d.pend_v  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl       = s_q.ctl;
    assign rx_permit = s_q.rx_permit;
endmodule

// File: rtl/smc_decode.sv
module smc_decode
    import smc_pkg::*;
(
    input  ctl_t              ctl,
    input  logic              fmt_sync,
    output logic [REG_W-1:0]  rdata,
    output logic [MODE_W-1:0] mode,
    output logic              pins_drive,
    output logic              clk_out_en,
    output logic [CKS_W-1:0]  clk_sel
);
    always_comb begin
        rdata      = ctl;
        mode       = {ctl.mst, ctl.trs};
        pins_drive = ctl.en;
        clk_out_en = ctl.en & ctl.mst & fmt_sync;
        clk_sel    = ctl.mst ? ctl.cks : '0;
    end
endmodule

// File: rtl/serial_mode_ctl.sv
module serial_mode_ctl
    import smc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              rx_rd,
    input  logic              fmt_sync,
    input  logic              arb_lost,
    input  logic              frame_busy,
    input  logic              frame_done,
    output logic [MODE_W-1:0] mode,
    output logic              pins_drive,
    output logic              clk_out_en,
    output logic [CKS_W-1:0]  clk_sel,
    output logic              rx_permit
);
    ctl_t ctl;

    smc_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .rx_rd      (rx_rd),
        .fmt_sync   (fmt_sync),
        .arb_lost   (arb_lost),
        .frame_busy (frame_busy),
        .frame_done (frame_done),
        .ctl        (ctl),
        .rx_permit  (rx_permit)
    );

    smc_decode u_decode (
        .ctl        (ctl),
        .fmt_sync   (fmt_sync),
        .rdata      (reg_rdata),
        .mode       (mode),
        .pins_drive (pins_drive),
        .clk_out_en (clk_out_en),
        .clk_sel    (clk_sel)
    );
endmodule

// File: rtl/smc_checker.sv
module smc_checker
    import smc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              rx_rd,
    input logic              fmt_sync,
    input logic              arb_lost,
    input logic              frame_busy,
    input logic              frame_done,
    input logic [MODE_W-1:0] mode,
    input logic              pins_drive,
    input logic              clk_out_en,
    input logic [CKS_W-1:0]  clk_sel,
    input logic              rx_permit
);
    a_r5_arb_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && mode[1] && !fmt_sync) |=> (mode == 2'b00));

    a_r7_permit_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rx_permit |-> ($past(rx_rd) && $past(reg_rdata[B_EN])
                       && !$past(reg_rdata[B_TRS]) && !$past(reg_rdata[B_HOLD])));

    a_r8_slave_no_clk_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |-> (clk_sel == '0));

    a_r9_clk_out_cond: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out_en |-> (fmt_sync && mode[1] && pins_drive));

    a_r10_trs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_busy && !frame_done && !arb_lost) |=> $stable(reg_rdata[B_TRS]));
endmodule

bind serial_mode_ctl smc_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rdata  (reg_rdata),
    .rx_rd      (rx_rd),
    .fmt_sync   (fmt_sync),
    .arb_lost   (arb_lost),
    .frame_busy (frame_busy),
    .frame_done (frame_done),
    .mode       (mode),
    .pins_drive (pins_drive),
    .clk_out_en (clk_out_en),
    .clk_sel    (clk_sel),
    .rx_permit  (rx_permit)
);

// File: tb/test_serial_mode_ctl.sv
module test_serial_mode_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       reg_wr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       rx_rd = 0;
    logic       fmt_sync = 0;
    logic       arb_lost = 0;
    logic       frame_busy = 0;
    logic       frame_done = 0;
    logic [1:0] mode;
    logic       pins_drive;
    logic       clk_out_en;
    logic [3:0] clk_sel;
    logic       rx_permit;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    serial_mode_ctl i_serial_mode_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_rd(rx_rd), .fmt_sync(fmt_sync),
        .arb_lost(arb_lost), .frame_busy(frame_busy), .frame_done(frame_done),
        .mode(mode), .pins_drive(pins_drive), .clk_out_en(clk_out_en),
        .clk_sel(clk_sel), .rx_permit(rx_permit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wr = 1; reg_wdata = v;
        tick();
        reg_wr = 0;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 rdata", reg_rdata, 0);
        chk("R1 mode", mode, 0);
        chk("R1 permit", rx_permit, 0);
        chk("R1 pins", pins_drive, 0);
        chk("R1 clk_out", clk_out_en, 0);
        chk("R1 clk_sel", clk_sel, 0);

        // R2 R3 R4 R8 R9 full sweep of values and formats
        for (int f = 0; f < 2; f++) begin
            fmt_sync = f[0];
            for (int v = 0; v < 256; v++) begin
                logic [7:0] b;
                b = v[7:0];
                wr(b);
                chk("R2 readback", reg_rdata, b);
                chk("R3 pins", pins_drive, b[7]);
                chk("R4 mode", mode, b[5:4]);
                chk("R8 clk_sel", clk_sel, b[5] ? b[3:0] : 4'd0);
                chk("R9 clk_out", clk_out_en, b[7] & b[5] & f[0]);
            end
        end

        // R7 reception gating over enable/transmit/hold
        fmt_sync = 0;
        for (int c = 0; c < 8; c++) begin
            logic en, tr, hd;
            en = c[2]; tr = c[1]; hd = c[0];
            wr({en, hd, 1'b0, tr, 4'h0});
            tick();
            chk("R7 idle no pulse", rx_permit, 0);
            rx_rd = 1;
            tick();
            rx_rd = 0;
            chk("R7 permit", rx_permit, en & ~tr & ~hd);
            tick();
            chk("R7 one cycle", rx_permit, 0);
        end

        // R5 arbitration loss in bus format as master transmit
        fmt_sync = 0;
        wr(8'hB5);
        arb_lost = 1; tick(); arb_lost = 0;
        chk("R5 cleared rdata", reg_rdata, 8'h85);
        chk("R5 mode slave rx", mode, 0);
        chk("R8 clk_sel after fallback", clk_sel, 0);
        // R5 ignored in synchronous format
        fmt_sync = 1;
        wr(8'hB5);
        arb_lost = 1; tick(); arb_lost = 0;
        chk("R5 sync ignored", reg_rdata, 8'hB5);
        chk("R9 clk_out sync master", clk_out_en, 1);
        // R5 slave: nothing to clear
        fmt_sync = 0;
        wr(8'h90);
        arb_lost = 1; tick(); arb_lost = 0;
        chk("R5 slave unchanged", reg_rdata, 8'h90);

        // R6 same-cycle write and arbitration clear
        wr(8'hB0);
        reg_wr = 1; reg_wdata = 8'hF3; arb_lost = 1;
        tick();
        reg_wr = 0; arb_lost = 0;
        chk("R6 hw clear wins", reg_rdata, 8'hC3);

        // R10 transmit-select write held during a frame
        wr(8'h80);
        frame_busy = 1;
        wr(8'h97);
        chk("R10 trs held, others apply", reg_rdata, 8'h87);
        tick();
        chk("R10 still held", reg_rdata, 8'h87);
        frame_done = 1; frame_busy = 0;
        tick();
        frame_done = 0;
        chk("R10 applied at frame end", reg_rdata, 8'h97);
        chk("R4 mode slave tx", mode, 2'b01);

        // R11 arbitration clear discards held write
        wr(8'hA0);
        frame_busy = 1;
        wr(8'hB0);
        chk("R10 held master", reg_rdata, 8'hA0);
        arb_lost = 1; tick(); arb_lost = 0;
        chk("R11 arb clear", reg_rdata, 8'h80);
        frame_done = 1; frame_busy = 0;
        tick();
        frame_done = 0;
        chk("R11 pending dropped", reg_rdata, 8'h80);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule